// File: doc/BRIEF.md
# Dual-Thread Two-Level Branch Predictor

This block predicts the direction and target of branches for an in-order core that runs two hardware threads. Each cycle the fetch stage may present a fetch PC with a thread number. One cycle later the block returns a taken/not-taken guess, a flag saying whether the target buffer holds the PC, and the stored target. Direction comes from a shared table of small state entries. Each entry is selected by XORing the PC with a per-thread record of recent conditional outcomes.

When a branch resolves, the pipeline sends its PC, thread, real outcome, real target and whether it was unconditional. One cycle later the block reports two separate indications. One flags a wrong direction, which costs a long flush. The other flags a correct taken direction whose target was absent or stale, which costs a shorter redirect. In the same cycle the block trains its state. Unconditional jumps only train the target buffer. A table entry whose branch has so far gone only one way predicts from that record and not from its counter.

All storage is flip-flops. The default table has 2^11 entries. Setting IDX_W to 13 gives the full 8192-entry table.

Top module: `dualThreadBranchPredictor`

## Requirements
- R1: After reset, both histories are zero, every table entry holds counter 01 with bias state unseen, and every target-buffer entry is invalid. A lookup then predicts not-taken with predHit low.
- R2: predValid is high exactly one cycle after lkValid. The predicted values are computed from the state before any resolution in the same cycle, so a same-cycle update is seen only by the following lookup.
- R3: The table index is PC[IDX_W+1:2] XOR the thread's history folded to IDX_W bits. History bit i is XORed into index bit i mod IDX_W.
- R4: Each thread owns a HIST_W-bit (default 12) history. A conditional resolution shifts its outcome (1 = taken) into bit 0 of that thread's history only.
- R5: The bias state is one of unseen(0), always-taken(1), never-taken(2) or mixed(3). The first conditional outcome moves unseen to always-taken or never-taken. The first opposite outcome moves it to mixed. Always-taken predicts taken and never-taken predicts not-taken whatever the counter holds. Unseen and mixed predict the counter's upper bit.
- R6: On every conditional resolution, the 2-bit counter at the index increments on taken and decrements on not-taken, saturating at 11 and 00.
- R7: An unconditional resolution leaves both histories and the whole table unchanged, and never raises resMispredict.
- R8: The target buffer has SETS=32 sets of WAYS=4 ways. The set is PC[6:2] and the tag is PC[31:7]. A lookup hit returns that entry's target, and the buffer is shared by both threads.
- R9: A taken or unconditional resolution writes the target buffer. On a hit it rewrites that way's target. Otherwise it fills the lowest invalid way, or, when the set is full, the way named by a tree pseudo-LRU (node bit 0 points to the lower half), which is then marked most recent. A not-taken resolution leaves the buffer unchanged.
- R10: One cycle after resValid, resDone is high. resMispredict is high for a conditional branch whose prediction, taken from current state, differs from the outcome. resTargetMiss is high for a taken branch without a direction mispredict whose target buffer missed or held a different target.
- R11: Both threads read and train the same table, so training by one thread changes the prediction seen by the other at the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| lkValid | input | 1 | Lookup request |
| lkPc | input | 32 | Fetch PC to look up |
| lkTid | input | 1 | Thread of the lookup |
| predValid | output | 1 | Lookup result valid |
| predTaken | output | 1 | Predicted direction |
| predHit | output | 1 | Target buffer holds the PC |
| predTarget | output | 32 | Stored target on a hit |
| resValid | input | 1 | Resolution present |
| resPc | input | 32 | Resolved branch PC |
| resTid | input | 1 | Thread of the resolved branch |
| resTaken | input | 1 | Real outcome |
| resTarget | input | 32 | Real target |
| resUncond | input | 1 | Branch is an unconditional jump |
| resDone | output | 1 | Resolution flags valid |
| resMispredict | output | 1 | Direction was wrong |
| resTargetMiss | output | 1 | Direction right, target absent or stale |

## Verification
A lookup and a resolution can land in the same cycle, on the same PC and thread. The bench drives both together on a PC the buffer has never held. It expects the lookup to report a miss and the resolution to report a target miss. A lookup in the following cycle must then hit with the new target. Other same-cycle pairs come from a stimulus table that is judged against a behavioural model in the bench, which applies every update only after computing both results of the cycle.

// File: rtl/bpPkg.sv
package bpPkg;

  typedef enum logic [1:0] {
    BIAS_UNSEEN   = 2'd0,
    BIAS_TAKEN    = 2'd1,
    BIAS_NOTTAKEN = 2'd2,
    BIAS_MIXED    = 2'd3
  } biasT;

  // Strobes from control to datapath
  typedef struct packed {
    logic capLookup;
    logic capResolve;
    logic trainDir;
    logic writeTarget;
  } bpStrobesT;

  function automatic logic predictDir(input biasT b, input logic [1:0] c);
    case (b)
      BIAS_TAKEN:    return 1'b1;
      BIAS_NOTTAKEN: return 1'b0;
      default:       return c[1];
    endcase
  endfunction

  function automatic biasT nextBias(input biasT b, input logic t);
    case (b)
      BIAS_UNSEEN:   return t ? BIAS_TAKEN : BIAS_NOTTAKEN;
      BIAS_TAKEN:    return t ? BIAS_TAKEN : BIAS_MIXED;
      BIAS_NOTTAKEN: return t ? BIAS_MIXED : BIAS_NOTTAKEN;
      default:       return BIAS_MIXED;
    endcase
  endfunction

  function automatic logic [1:0] nextCtr(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

endpackage

// File: rtl/bpCtrl.sv
module bpCtrl
  import bpPkg::*;
(
  input  logic      lkValid,
  input  logic      resValid,
  input  logic      resTaken,
  input  logic      resUncond,
  output bpStrobesT strobes
);

  always_comb begin
    strobes.capLookup   = lkValid;
    strobes.capResolve  = resValid;
    strobes.trainDir    = resValid && !resUncond;
    strobes.writeTarget = resValid && (resTaken || resUncond);
  end

endmodule

// File: rtl/bpDatapath.sv
module bpDatapath
  import bpPkg::*;
#(
  parameter int PC_W    = 32,
  parameter int HIST_W  = 12,
  parameter int IDX_W   = 11,
  parameter int THREADS = 2,
  parameter int SETS    = 32,
  parameter int WAYS    = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bpStrobesT                  strobes,
  input  logic [PC_W-1:0]            lkPc,
  input  logic [$clog2(THREADS)-1:0] lkTid,
  input  logic [PC_W-1:0]            resPc,
  input  logic [$clog2(THREADS)-1:0] resTid,
  input  logic                       resTaken,
  input  logic [PC_W-1:0]            resTarget,
  output logic                       predValid,
  output logic                       predTaken,
  output logic                       predHit,
  output logic [PC_W-1:0]            predTarget,
  output logic                       resDone,
  output logic                       resMispredict,
  output logic                       resTargetMiss
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int TAG_W   = PC_W - SET_W - 2;
  localparam int LVL     = WAY_W;

  logic [HIST_W-1:0] hist   [THREADS];
  logic [1:0]        ctr    [ENTRIES];
  biasT              bias   [ENTRIES];
  logic              vld    [SETS][WAYS];
  logic [TAG_W-1:0]  tagArr [SETS][WAYS];
  logic [PC_W-1:0]   tgtArr [SETS][WAYS];
  logic [WAYS-1:1]   plru   [SETS];

  logic unusedPcLow;
  assign unusedPcLow = ^{lkPc[1:0], resPc[1:0]};

  function automatic logic [IDX_W-1:0] foldHist(input logic [HIST_W-1:0] h);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < HIST_W; i++) r[i % IDX_W] = r[i % IDX_W] ^ h[i];
    return r;
  endfunction

  // Lookup side
  logic [IDX_W-1:0] lkIdx;
  logic [SET_W-1:0] lkSet;
  logic [TAG_W-1:0] lkTag;
  logic             lkHit, lkDir;
  logic [PC_W-1:0]  lkTgt;

  always_comb begin
    lkIdx = lkPc[IDX_W+1:2] ^ foldHist(hist[lkTid]);
    lkDir = predictDir(bias[lkIdx], ctr[lkIdx]);
    lkSet = lkPc[SET_W+1:2];
    lkTag = lkPc[PC_W-1:SET_W+2];
    lkHit = 1'b0;
    lkTgt = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[lkSet][w] && tagArr[lkSet][w] == lkTag) begin
        lkHit = 1'b1;
        lkTgt = tgtArr[lkSet][w];
      end
    end
  end

  // Resolution side
  logic [IDX_W-1:0] rsIdx;
  logic [SET_W-1:0] rsSet;
  logic [TAG_W-1:0] rsTag;
  logic             rsHit, rsDir, rsHasFree, rsMis;
  logic [PC_W-1:0]  rsTgt;
  logic [WAY_W-1:0] rsHitWay, rsFreeWay, rsVictim, rsWay;
  logic [WAYS-1:1]  rsBits, rsNewBits;

  always_comb begin
    int node;
    rsIdx = resPc[IDX_W+1:2] ^ foldHist(hist[resTid]);
    rsDir = predictDir(bias[rsIdx], ctr[rsIdx]);
    rsMis = strobes.trainDir && (rsDir != resTaken);
    rsSet = resPc[SET_W+1:2];
    rsTag = resPc[PC_W-1:SET_W+2];
    rsHit = 1'b0;
    rsTgt = '0;
    rsHitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[rsSet][w] && tagArr[rsSet][w] == rsTag) begin
        rsHit    = 1'b1;
        rsTgt    = tgtArr[rsSet][w];
        rsHitWay = WAY_W'(w);
      end
    end
    rsHasFree = 1'b0;
    rsFreeWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld[rsSet][w]) begin
        rsHasFree = 1'b1;
        rsFreeWay = WAY_W'(w);
      end
    end
    rsBits = plru[rsSet];
    node = 1;
    for (int l = 0; l < LVL; l++) node = node * 2 + (rsBits[node] ? 1 : 0);
    rsVictim = WAY_W'(node - WAYS);
    rsWay = rsHit ? rsHitWay : (rsHasFree ? rsFreeWay : rsVictim);
    rsNewBits = rsBits;
    node = int'(rsWay) + WAYS;
    for (int l = 0; l < LVL; l++) begin
      rsNewBits[node / 2] = ((node % 2) == 0);
      node = node / 2;
    end
  end

  // Registered results
  always_ff @(posedge clk) begin
    if (!rstN) begin
      predValid     <= 1'b0;
      predTaken     <= 1'b0;
      predHit       <= 1'b0;
      predTarget    <= '0;
      resDone       <= 1'b0;
      resMispredict <= 1'b0;
      resTargetMiss <= 1'b0;
    end else begin
      predValid     <= strobes.capLookup;
      predTaken     <= lkDir;
      predHit       <= lkHit;
      predTarget    <= lkTgt;
      resDone       <= strobes.capResolve;
      resMispredict <= rsMis;
      resTargetMiss <= strobes.writeTarget && !rsMis && !(rsHit && rsTgt == resTarget);
    end
  end

  // Direction state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < THREADS; t++) hist[t] <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        ctr[e]  <= 2'b01;
        bias[e] <= BIAS_UNSEEN;
      end
    end else if (strobes.trainDir) begin
      ctr[rsIdx]   <= nextCtr(ctr[rsIdx], resTaken);
      bias[rsIdx]  <= nextBias(bias[rsIdx], resTaken);
      hist[resTid] <= {hist[resTid][HIST_W-2:0], resTaken};
    end
  end

  // Target buffer state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        plru[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          vld[s][w]    <= 1'b0;
          tagArr[s][w] <= '0;
          tgtArr[s][w] <= '0;
        end
      end
    end else if (strobes.writeTarget) begin
      vld[rsSet][rsWay]    <= 1'b1;
      tagArr[rsSet][rsWay] <= rsTag;
      tgtArr[rsSet][rsWay] <= resTarget;
      plru[rsSet]          <= rsNewBits;
    end
  end

endmodule

// File: rtl/dualThreadBranchPredictor.sv
module dualThreadBranchPredictor
  import bpPkg::*;
#(
  parameter int PC_W    = 32,
  parameter int HIST_W  = 12,
  parameter int IDX_W   = 11,
  parameter int THREADS = 2,
  parameter int SETS    = 32,
  parameter int WAYS    = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       lkValid,
  input  logic [PC_W-1:0]            lkPc,
  input  logic [$clog2(THREADS)-1:0] lkTid,
  output logic                       predValid,
  output logic                       predTaken,
  output logic                       predHit,
  output logic [PC_W-1:0]            predTarget,
  input  logic                       resValid,
  input  logic [PC_W-1:0]            resPc,
  input  logic [$clog2(THREADS)-1:0] resTid,
  input  logic                       resTaken,
  input  logic [PC_W-1:0]            resTarget,
  input  logic                       resUncond,
  output logic                       resDone,
  output logic                       resMispredict,
  output logic                       resTargetMiss
);

  bpStrobesT strobes;

  bpCtrl uCtrl (
    .lkValid  (lkValid),
    .resValid (resValid),
    .resTaken (resTaken),
    .resUncond(resUncond),
    .strobes  (strobes)
  );

  bpDatapath #(
    .PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W),
    .THREADS(THREADS), .SETS(SETS), .WAYS(WAYS)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .lkPc         (lkPc),
    .lkTid        (lkTid),
    .resPc        (resPc),
    .resTid       (resTid),
    .resTaken     (resTaken),
    .resTarget    (resTarget),
    .predValid    (predValid),
    .predTaken    (predTaken),
    .predHit      (predHit),
    .predTarget   (predTarget),
    .resDone      (resDone),
    .resMispredict(resMispredict),
    .resTargetMiss(resTargetMiss)
  );

endmodule

// File: rtl/bpChecker.sv
module bpChecker (
  input logic clk,
  input logic rstN,
  input logic lkValid,
  input logic predValid,
  input logic resValid,
  input logic resTaken,
  input logic resUncond,
  input logic resDone,
  input logic resMispredict,
  input logic resTargetMiss
);

  // R2
  lookup_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> predValid);

  // R2
  idle_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !predValid);

  // R10
  flags_need_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resMispredict || resTargetMiss) |-> resDone);

  // R10
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(resMispredict && resTargetMiss));

  // R7
  jump_no_mispredict_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resUncond) |=> !resMispredict);

  // R10
  not_taken_no_target_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resTaken && !resUncond) |=> !resTargetMiss);

endmodule

bind dualThreadBranchPredictor bpChecker uChk (.*);

// File: tb/tb_dualThreadBranchPredictor.sv
module tb_dualThreadBranchPredictor;

  localparam int PC_W = 32, HIST_W = 12, IDX_W = 11, SETS = 32, WAYS = 4;
  localparam int ENTRIES = 1 << IDX_W;

  logic clk = 1'b0;
  logic rstN;
  logic lkValid, lkTid, resValid, resTid, resTaken, resUncond;
  logic [PC_W-1:0] lkPc, resPc, resTarget, predTarget;
  logic predValid, predTaken, predHit, resDone, resMispredict, resTargetMiss;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  dualThreadBranchPredictor dut (.*);

  // Behavioural model
  logic [HIST_W-1:0] mHist [2];
  logic [1:0]        mCtr  [ENTRIES];
  logic [1:0]        mBias [ENTRIES];
  logic              mVld  [SETS][WAYS];
  logic [24:0]       mTag  [SETS][WAYS];
  logic [31:0]       mTgt  [SETS][WAYS];
  logic [3:1]        mPlru [SETS];

  function automatic logic [IDX_W-1:0] mIdx(input logic [31:0] pc, input logic [HIST_W-1:0] h);
    logic [IDX_W-1:0] f;
    f = h[10:0] ^ {10'b0, h[11]};
    return pc[12:2] ^ f;
  endfunction

  function automatic logic mDir(input logic [1:0] b, input logic [1:0] c);
    if (b == 2'd1) return 1'b1;
    if (b == 2'd2) return 1'b0;
    return c[1];
  endfunction

  task automatic mBtb(input logic [31:0] pc, output logic hit, output logic [31:0] tgt, output int way);
    hit = 1'b0; tgt = '0; way = 0;
    for (int w = 0; w < WAYS; w++)
      if (mVld[pc[6:2]][w] && mTag[pc[6:2]][w] == pc[31:7]) begin
        hit = 1'b1; tgt = mTgt[pc[6:2]][w]; way = w;
      end
  endtask

  task automatic modelReset();
    for (int t = 0; t < 2; t++) mHist[t] = '0;
    for (int e = 0; e < ENTRIES; e++) begin mCtr[e] = 2'b01; mBias[e] = 2'd0; end
    for (int s = 0; s < SETS; s++) begin
      mPlru[s] = '0;
      for (int w = 0; w < WAYS; w++) begin mVld[s][w] = 1'b0; mTag[s][w] = '0; mTgt[s][w] = '0; end
    end
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compute model results, update model, sample next negedge
  task automatic step(input logic lv, input logic [31:0] lpc, input logic ltid,
                      input logic rv, input logic [31:0] rpc, input logic rtid,
                      input logic rtk, input logic runc, input logic [31:0] rtgt);
    logic eDir, eHit, rDir, rHit, eMis, eTm;
    logic [31:0] eTgt, rTgt;
    logic [IDX_W-1:0] li, ri;
    int dw, hw, way, node;
    logic [4:0] s;
    lkValid = lv; lkPc = lpc; lkTid = ltid;
    resValid = rv; resPc = rpc; resTid = rtid; resTaken = rtk; resUncond = runc; resTarget = rtgt;
    li = mIdx(lpc, mHist[ltid]);
    eDir = mDir(mBias[li], mCtr[li]);
    mBtb(lpc, eHit, eTgt, dw);
    ri = mIdx(rpc, mHist[rtid]);
    rDir = mDir(mBias[ri], mCtr[ri]);
    mBtb(rpc, rHit, rTgt, hw);
    eMis = rv && !runc && (rDir != rtk);
    eTm = rv && (rtk || runc) && !eMis && !(rHit && rTgt == rtgt);
    if (rv && !runc) begin
      if (rtk) mCtr[ri] = (mCtr[ri] == 2'b11) ? 2'b11 : mCtr[ri] + 2'b01;
      else     mCtr[ri] = (mCtr[ri] == 2'b00) ? 2'b00 : mCtr[ri] - 2'b01;
      if (mBias[ri] == 2'd0) mBias[ri] = rtk ? 2'd1 : 2'd2;
      else if ((mBias[ri] == 2'd1 && !rtk) || (mBias[ri] == 2'd2 && rtk)) mBias[ri] = 2'd3;
      mHist[rtid] = {mHist[rtid][HIST_W-2:0], rtk};
    end
    if (rv && (rtk || runc)) begin
      s = rpc[6:2];
      if (rHit) way = hw;
      else begin
        way = -1;
        for (int w = WAYS - 1; w >= 0; w--) if (!mVld[s][w]) way = w;
        if (way < 0) begin
          node = 1;
          for (int l = 0; l < 2; l++) node = node * 2 + (mPlru[s][node] ? 1 : 0);
          way = node - WAYS;
        end
      end
      mVld[s][way] = 1'b1; mTag[s][way] = rpc[31:7]; mTgt[s][way] = rtgt;
      node = way + WAYS;
      for (int l = 0; l < 2; l++) begin mPlru[s][node / 2] = ((node % 2) == 0); node = node / 2; end
    end
    @(negedge clk);
    chk("R2", "predValid", {31'b0, predValid}, {31'b0, lv});
    if (lv) begin
      chk("R5", "predTaken", {31'b0, predTaken}, {31'b0, eDir});
      chk("R8", "predHit", {31'b0, predHit}, {31'b0, eHit});
      if (eHit) chk("R8", "predTarget", predTarget, eTgt);
    end
    chk("R10", "resDone", {31'b0, resDone}, {31'b0, rv});
    if (rv) begin
      chk("R10", "resMispredict", {31'b0, resMispredict}, {31'b0, eMis});
      chk("R10", "resTargetMiss", {31'b0, resTargetMiss}, {31'b0, eTm});
    end
  endtask

  task automatic look(input logic [31:0] pc, input logic tid);
    step(1'b1, pc, tid, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic resolve(input logic [31:0] pc, input logic tid, input logic tk,
                         input logic unc, input logic [31:0] tgt);
    step(1'b0, 32'h0, 1'b0, 1'b1, pc, tid, tk, unc, tgt);
  endtask

  typedef struct packed {
    logic        lv;
    logic [15:0] lpc;
    logic        ltid;
    logic        rv;
    logic [15:0] rpc;
    logic        rtid;
    logic        rtk;
    logic        runc;
    logic [15:0] rtgt;
  } vecT;

  localparam int NVEC = 14;
  localparam vecT VECS [NVEC] = '{
    '{1'b1, 16'h5004, 1'b0, 1'b1, 16'h5004, 1'b0, 1'b1, 1'b0, 16'h6000},
    '{1'b1, 16'h5004, 1'b0, 1'b1, 16'h5004, 1'b0, 1'b1, 1'b0, 16'h6000},
    '{1'b1, 16'h5004, 1'b1, 1'b1, 16'h5004, 1'b1, 1'b0, 1'b0, 16'h6000},
    '{1'b1, 16'h5104, 1'b1, 1'b1, 16'h5104, 1'b1, 1'b1, 1'b0, 16'h7000},
    '{1'b1, 16'h5104, 1'b0, 1'b1, 16'h5104, 1'b0, 1'b1, 1'b0, 16'h7004},
    '{1'b0, 16'h0000, 1'b0, 1'b1, 16'h5208, 1'b0, 1'b1, 1'b1, 16'h7100},
    '{1'b1, 16'h5208, 1'b1, 1'b1, 16'h5004, 1'b1, 1'b1, 1'b0, 16'h6000},
    '{1'b1, 16'h5004, 1'b1, 1'b1, 16'h5004, 1'b0, 1'b0, 1'b0, 16'h6000},
    '{1'b1, 16'h5004, 1'b0, 1'b1, 16'h5004, 1'b0, 1'b0, 1'b0, 16'h6000},
    '{1'b1, 16'h5004, 1'b0, 1'b1, 16'h5004, 1'b0, 1'b0, 1'b0, 16'h6000},
    '{1'b1, 16'h5104, 1'b1, 1'b1, 16'h5104, 1'b1, 1'b1, 1'b0, 16'h7000},
    '{1'b1, 16'h5104, 1'b1, 1'b1, 16'h5104, 1'b1, 1'b1, 1'b0, 16'h7008},
    '{1'b1, 16'h5104, 1'b0, 1'b1, 16'h5104, 1'b0, 1'b0, 1'b0, 16'h7008},
    '{1'b1, 16'h5208, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    lkValid = 0; lkPc = 0; lkTid = 0; resValid = 0; resPc = 0; resTid = 0;
    resTaken = 0; resTarget = 0; resUncond = 0;
    modelReset();
    repeat (3) @(negedge clk);
    // R1 outputs idle in reset
    chk("R1", "predValid in reset", {31'b0, predValid}, 32'd0);
    chk("R1", "resDone in reset", {31'b0, resDone}, 32'd0);
    rstN = 1'b1;

    // R1 first lookup: not taken, no hit
    look(32'h1004, 1'b0);
    chk("R1", "reset predTaken", {31'b0, predTaken}, 32'd0);
    chk("R1", "reset predHit", {31'b0, predHit}, 32'd0);

    // R10 first taken conditional mispredicts, no target miss
    resolve(32'h1004, 1'b0, 1'b1, 1'b0, 32'h5000);
    chk("R10", "first taken mispredict", {31'b0, resMispredict}, 32'd1);
    chk("R10", "first taken target miss", {31'b0, resTargetMiss}, 32'd0);

    // R3 t0 history now 1: pc 0x1000 aliases to index of 0x1004 -> always-taken
    look(32'h1000, 1'b0);
    chk("R3", "xor alias predTaken", {31'b0, predTaken}, 32'd1);

    // R11 R4 thread 1 history zero sees thread 0 training; R8 shared target
    look(32'h1004, 1'b1);
    chk("R11", "shared table predTaken", {31'b0, predTaken}, 32'd1);
    chk("R8", "shared target", predTarget, 32'h5000);

    // R7 jump on same pc keeps t1 history and table
    resolve(32'h1004, 1'b1, 1'b1, 1'b1, 32'h5000);
    chk("R7", "jump no mispredict", {31'b0, resMispredict}, 32'd0);
    look(32'h1004, 1'b1);
    chk("R7", "history unchanged predTaken", {31'b0, predTaken}, 32'd1);

    // R5 opposite outcome -> mixed, counter 01 -> not taken
    resolve(32'h1004, 1'b1, 1'b0, 1'b0, 32'h0);
    chk("R5", "always-taken broken mispredict", {31'b0, resMispredict}, 32'd1);
    look(32'h1004, 1'b1);
    chk("R5", "mixed uses counter", {31'b0, predTaken}, 32'd0);
    chk("R9", "not-taken keeps entry", {31'b0, predHit}, 32'd1);

    // R10 target-miss sequence with jumps
    resolve(32'h3010, 1'b0, 1'b1, 1'b1, 32'h8000);
    chk("R10", "cold jump target miss", {31'b0, resTargetMiss}, 32'd1);
    resolve(32'h3010, 1'b0, 1'b1, 1'b1, 32'h8000);
    chk("R10", "warm jump no target miss", {31'b0, resTargetMiss}, 32'd0);
    resolve(32'h3010, 1'b0, 1'b1, 1'b1, 32'h9000);
    chk("R10", "stale target miss", {31'b0, resTargetMiss}, 32'd1);
    look(32'h3010, 1'b0);
    chk("R9", "target rewritten", predTarget, 32'h9000);

    // R2 same-cycle lookup and resolution
    step(1'b1, 32'h4018, 1'b0, 1'b1, 32'h4018, 1'b0, 1'b1, 1'b1, 32'hA000);
    chk("R2", "same-cycle lookup sees old", {31'b0, predHit}, 32'd0);
    chk("R2", "same-cycle target miss", {31'b0, resTargetMiss}, 32'd1);
    look(32'h4018, 1'b0);
    chk("R2", "next lookup sees update", {31'b0, predHit}, 32'd1);
    chk("R2", "next lookup target", predTarget, 32'hA000);

    // R9 fill set 0 then evict by pseudo-LRU (victim is way of 0x080)
    for (int k = 1; k <= 5; k++)
      resolve(32'(k * 32'h80), 1'b0, 1'b1, 1'b1, 32'(k * 32'h80 + 32'h1000));
    look(32'h0080, 1'b0);
    chk("R9", "plru victim evicted", {31'b0, predHit}, 32'd0);
    look(32'h0100, 1'b0);
    chk("R9", "survivor hit", {31'b0, predHit}, 32'd1);
    chk("R9", "survivor target", predTarget, 32'h1100);
    look(32'h0280, 1'b0);
    chk("R9", "new entry hit", {31'b0, predHit}, 32'd1);

    // R6 R5 R10 table-driven patterns against the model
    for (int i = 0; i < NVEC; i++)
      step(VECS[i].lv, {16'h0, VECS[i].lpc}, VECS[i].ltid, VECS[i].rv, {16'h0, VECS[i].rpc},
           VECS[i].rtid, VECS[i].rtk, VECS[i].runc, {16'h0, VECS[i].rtgt});

    // R6 saturation: many taken on one pc/thread, then one not-taken
    for (int i = 0; i < 6; i++) resolve(32'h7700, 1'b1, 1'b1, 1'b0, 32'h7800);
    resolve(32'h7700, 1'b1, 1'b0, 1'b0, 32'h0);
    look(32'h7700, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule